// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block produces the running colour subcarrier phase for an analog television encoder. It does so with three chained modular accumulators, so that an irrational-looking ratio such as the NTSC or PAL subcarrier frequency over the pixel clock is reproduced as an exact fraction. The first accumulator is 12 bits wide and its value is the phase word. The second accumulator adds its own increment modulo a programmable size, and each time it wraps it adds one extra count to the phase. The third accumulator works the same way, and each of its wraps adds one extra count to the second.

Each accepted pixel (`pix_vld` high) advances all three stages once. End-of-field pulses are counted. When the count reaches the selected period of 2, 4 or 8 fields, every accumulator returns to zero, so the phase pattern repeats from field to field as the broadcast standard demands. A fourth mode never clears them. The sine lookup and the burst amplitude stage are downstream and are not part of this block. The configuration is expected to be static while the block runs and is changed only while reset is held.

Top module: `sc_phase_dda`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `phase_o` is 0.
- R2: Each cycle with `pix_vld` high and no field clear, `phase_o` becomes (previous `phase_o` + `cfg_inc1` + carry from the second stage) modulo 4096. The result is visible one clock edge after the strobe.
- R3: The second stage adds `cfg_inc2`, plus the third stage's carry, modulo `cfg_size2`. When this sum reaches `cfg_size2`, one extra count goes into the phase on that same pixel. When `cfg_size2` is 0 the second stage is idle and gives no carry.
- R4: The third stage adds `cfg_inc3` modulo `cfg_size3`. When this sum reaches `cfg_size3`, one extra count goes into the second stage on that same pixel. When `cfg_size3` is 0 the third stage is idle and gives no carry.
- R5: After n accepted pixels since the last clear, with increments below their sizes, `phase_o` = (n·inc1 + ⌊(n·inc2 + ⌊n·inc3/size3⌋)/size2⌋) mod 4096. A floor term whose size is 0 counts as 0.
- R6: A cycle with `pix_vld` low and no field clear leaves `phase_o` unchanged.
- R7: `cfg_rst_mode` code 0 clears all stages on every 2nd `eof` pulse, code 1 on every 4th, and code 2 on every 8th. Code 3 never clears. After a clear, `phase_o` reads 0.
- R8: When a clearing `eof` arrives in the same cycle as `pix_vld`, the clear wins and that pixel is not counted.
- R9: An `eof` pulse that does not complete the field period has no effect on the phase. A pixel in the same cycle still advances it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_vld | input | 1 | Advances the accumulators by one pixel |
| eof | input | 1 | One-cycle end-of-field pulse |
| cfg_inc1 | input | 12 | Phase increment per pixel |
| cfg_size2 | input | 15 | Modulus of the second stage (0 = idle) |
| cfg_inc2 | input | 15 | Increment of the second stage |
| cfg_size3 | input | 15 | Modulus of the third stage (0 = idle) |
| cfg_inc3 | input | 15 | Increment of the third stage |
| cfg_rst_mode | input | 2 | Field clear period: 0=2, 1=4, 2=8, 3=never |
| phase_o | output | 12 | Current subcarrier phase |

## Verification
Every result has a latency of one clock edge. A pixel strobe or a clearing field pulse that is driven before an edge shows up in `phase_o` just after that edge. The bench drives inputs on the falling edge, waits for the next rising edge and samples one nanosecond later, so each check sees exactly one update. Expected phases come from the closed-form floor expression of R5, evaluated on the count of pixels since the last clear. The bench never replays the per-stage arithmetic. The field period is tracked by counting pulses in the bench, so the clear is expected on the exact pulse that completes the period.

// File: rtl/sc_dda_pkg.sv
package sc_dda_pkg;

  localparam int SC_FCNT_W = 3;

  typedef enum logic [1:0] {
    FCLR_EVERY2 = 2'd0,
    FCLR_EVERY4 = 2'd1,
    FCLR_EVERY8 = 2'd2,
    FCLR_NEVER  = 2'd3
  } fclr_mode_e;

  // Index of the last field of a clearing period (period - 1).
  function automatic logic [SC_FCNT_W-1:0] fclr_last(input fclr_mode_e m);
    case (m)
      FCLR_EVERY2: fclr_last = SC_FCNT_W'(1);
      FCLR_EVERY4: fclr_last = SC_FCNT_W'(3);
      default:     fclr_last = SC_FCNT_W'(7);
    endcase
  endfunction

endpackage

// File: rtl/sc_mod_acc.sv
module sc_mod_acc #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         clr,
  input  logic [W-1:0] inc,
  input  logic [W-1:0] size,
  input  logic         cin,
  output logic         wrap,
  output logic [W-1:0] acc_q
);

  localparam int SW = W + 1;

  // Sum of accumulator, increment and carry-in, one bit wider than the stage.
  function automatic logic [SW-1:0] raw_sum(input logic [W-1:0] a,
                                            input logic [W-1:0] b,
                                            input logic c);
    raw_sum = SW'(a) + SW'(b) + SW'(c);
  endfunction

  logic          active;
  logic [SW-1:0] sum;
  logic [W-1:0]  acc_d;

  assign active = (size != '0);
  assign sum    = raw_sum(acc_q, inc, cin);
  assign wrap   = step && active && (sum >= SW'(size));

  always_comb begin
    if (!active)      acc_d = '0;
    else if (wrap)    acc_d = W'(sum - SW'(size));
    else              acc_d = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)   acc_q <= '0;
    else if (step)    acc_q <= acc_d;
  end

endmodule

// File: rtl/sc_phase_acc.sv
module sc_phase_acc #(
  parameter int PH_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            clr,
  input  logic [PH_W-1:0] inc,
  input  logic            cin,
  output logic [PH_W-1:0] phase_q
);

  function automatic logic [PH_W-1:0] next_phase(input logic [PH_W-1:0] p,
                                                 input logic [PH_W-1:0] i,
                                                 input logic c);
    next_phase = p + i + PH_W'(c);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr)   phase_q <= '0;
    else if (step)    phase_q <= next_phase(phase_q, inc, cin);
  end

endmodule

// File: rtl/sc_field_sched.sv
module sc_field_sched
  import sc_dda_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       eof,
  input  logic [1:0] mode,
  output logic       field_clr
);

  logic [SC_FCNT_W-1:0] fcnt_q;
  fclr_mode_e           mode_e;
  logic                 period_done;

  assign mode_e      = fclr_mode_e'(mode);
  assign period_done = (fcnt_q >= fclr_last(mode_e));
  assign field_clr   = eof && (mode_e != FCLR_NEVER) && period_done;

  always_ff @(posedge clk) begin
    if (rst)             fcnt_q <= '0;
    else if (field_clr)  fcnt_q <= '0;
    else if (eof)        fcnt_q <= fcnt_q + SC_FCNT_W'(1);
  end

endmodule

// File: rtl/sc_phase_dda.sv
module sc_phase_dda #(
  parameter int PH_W = 12,
  parameter int FR_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pix_vld,
  input  logic            eof,
  input  logic [PH_W-1:0] cfg_inc1,
  input  logic [FR_W-1:0] cfg_size2,
  input  logic [FR_W-1:0] cfg_inc2,
  input  logic [FR_W-1:0] cfg_size3,
  input  logic [FR_W-1:0] cfg_inc3,
  input  logic [1:0]      cfg_rst_mode,
  output logic [PH_W-1:0] phase_o
);

  // Named internal events, observed by the bound checker.
  logic            field_clr;
  logic            pix_step;
  logic            carry2;
  logic            carry3;
  logic [FR_W-1:0] acc2_q;
  logic [FR_W-1:0] acc3_q;

  assign pix_step = pix_vld && !field_clr;

  sc_field_sched u_fsched (
    .clk       (clk),
    .rst       (rst),
    .eof       (eof),
    .mode      (cfg_rst_mode),
    .field_clr (field_clr)
  );

  sc_mod_acc #(.W(FR_W)) u_stage3 (
    .clk   (clk),
    .rst   (rst),
    .step  (pix_step),
    .clr   (field_clr),
    .inc   (cfg_inc3),
    .size  (cfg_size3),
    .cin   (1'b0),
    .wrap  (carry3),
    .acc_q (acc3_q)
  );

  sc_mod_acc #(.W(FR_W)) u_stage2 (
    .clk   (clk),
    .rst   (rst),
    .step  (pix_step),
    .clr   (field_clr),
    .inc   (cfg_inc2),
    .size  (cfg_size2),
    .cin   (carry3),
    .wrap  (carry2),
    .acc_q (acc2_q)
  );

  sc_phase_acc #(.PH_W(PH_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .step    (pix_step),
    .clr     (field_clr),
    .inc     (cfg_inc1),
    .cin     (carry2),
    .phase_q (phase_o)
  );

endmodule

// File: rtl/sc_phase_dda_chk.sv
module sc_phase_dda_chk #(
  parameter int PH_W = 12,
  parameter int FR_W = 15
) (
  input logic            clk,
  input logic            rst,
  input logic            pix_vld,
  input logic [PH_W-1:0] cfg_inc1,
  input logic [FR_W-1:0] cfg_size2,
  input logic [FR_W-1:0] cfg_size3,
  input logic [FR_W-1:0] acc2_q,
  input logic [FR_W-1:0] acc3_q,
  input logic [1:0]      cfg_rst_mode,
  input logic [PH_W-1:0] phase_o,
  input logic            carry2,
  input logic            carry3,
  input logic            field_clr
);

  logic [PH_W-1:0] nxt_ph;
  always_comb nxt_ph = phase_o + cfg_inc1 + PH_W'(carry2);

  // R1
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> phase_o == '0);

  // R2
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (pix_vld && !field_clr) |=> phase_o == $past(nxt_ph));

  // R3
  a_r3_idle_no_carry: assert property (@(posedge clk) disable iff (rst)
    (cfg_size2 == '0) |-> !carry2 && acc2_q == '0);

  // R4
  a_r4_idle_no_carry: assert property (@(posedge clk) disable iff (rst)
    (cfg_size3 == '0) |-> !carry3 && acc3_q == '0);

  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!pix_vld && !field_clr) |=> $stable(phase_o));

  // R7
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    field_clr |=> phase_o == '0 && acc2_q == '0 && acc3_q == '0);

  // R7
  a_r7_never: assert property (@(posedge clk) disable iff (rst)
    (cfg_rst_mode == 2'd3) |-> !field_clr);

  // R8
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (field_clr && pix_vld) |-> !carry2 && !carry3);

endmodule

bind sc_phase_dda sc_phase_dda_chk #(.PH_W(PH_W), .FR_W(FR_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .pix_vld      (pix_vld),
  .cfg_inc1     (cfg_inc1),
  .cfg_size2    (cfg_size2),
  .cfg_size3    (cfg_size3),
  .acc2_q       (acc2_q),
  .acc3_q       (acc3_q),
  .cfg_rst_mode (cfg_rst_mode),
  .phase_o      (phase_o),
  .carry2       (carry2),
  .carry3       (carry3),
  .field_clr    (field_clr)
);

// File: tb/sc_phase_dda_tb_top.sv
module sc_phase_dda_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_vld = 1'b0;
  logic        eof = 1'b0;
  logic [11:0] cfg_inc1 = '0;
  logic [14:0] cfg_size2 = '0;
  logic [14:0] cfg_inc2 = '0;
  logic [14:0] cfg_size3 = '0;
  logic [14:0] cfg_inc3 = '0;
  logic [1:0]  cfg_rst_mode = 2'd3;
  logic [11:0] phase_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model state: pixels since last clear, pulses since last clear.
  longint npix = 0;
  int     nfld = 0;

  always #2 clk = ~clk;

  sc_phase_dda dut_i (
    .clk          (clk),
    .rst          (rst),
    .pix_vld      (pix_vld),
    .eof          (eof),
    .cfg_inc1     (cfg_inc1),
    .cfg_size2    (cfg_size2),
    .cfg_inc2     (cfg_inc2),
    .cfg_size3    (cfg_size3),
    .cfg_inc3     (cfg_inc3),
    .cfg_rst_mode (cfg_rst_mode),
    .phase_o      (phase_o)
  );

  // Closed form of R5.
  function automatic longint expect_phase(input longint n);
    longint c3, c2;
    c3 = (cfg_size3 != 0) ? (n * longint'(cfg_inc3)) / longint'(cfg_size3) : 0;
    c2 = (cfg_size2 != 0) ? (n * longint'(cfg_inc2) + c3) / longint'(cfg_size2) : 0;
    return (n * longint'(cfg_inc1) + c2) % 4096;
  endfunction

  task automatic check(input string req, input longint exp);
    checks++;
    if (longint'(phase_o) != exp) begin
      errors++;
      $display("FAIL %s: phase actual %0d expected %0d (npix %0d)", req, phase_o, exp, npix);
    end
  endtask

  task automatic do_reset(input logic [11:0] i1, input logic [14:0] s2,
                          input logic [14:0] i2, input logic [14:0] s3,
                          input logic [14:0] i3, input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; pix_vld = 1'b0; eof = 1'b0;
    cfg_inc1 = i1; cfg_size2 = s2; cfg_inc2 = i2;
    cfg_size3 = s3; cfg_inc3 = i3; cfg_rst_mode = m;
    @(posedge clk); #1;
    check("R1", 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1", 0);
    npix = 0; nfld = 0;
  endtask

  // One cycle of stimulus, then a check one edge later.
  task automatic cyc(input bit v, input bit e, input string req);
    int period;
    bit clr;
    @(negedge clk);
    pix_vld = v; eof = e;
    @(posedge clk); #1;
    period = 2 << cfg_rst_mode;
    clr = 0;
    if (e) begin
      nfld++;
      if (cfg_rst_mode != 2'd3 && nfld >= period) begin
        clr = 1; nfld = 0; npix = 0;
      end
    end
    if (!clr && v) npix++;
    check(req, expect_phase(npix));
    @(negedge clk);
    pix_vld = 1'b0; eof = 1'b0;
  endtask

  initial begin
    // Sweep of small rational configurations (R3, R4, R5).
    for (int s2 = 3; s2 <= 7; s2 += 2)
      for (int i2 = 0; i2 < s2; i2++)
        for (int s3 = 0; s3 <= 3; s3++) begin
          if (s3 == 1) continue;
          for (int i3 = 0; i3 < ((s3 == 0) ? 1 : s3); i3++) begin
            do_reset(12'd4093, 15'(s2), 15'(i2), 15'(s3), 15'(i3), 2'd3);
            for (int k = 0; k < 24; k++)
              cyc(1'b1, 1'b0, (s3 != 0) ? "R4" : "R3");
          end
        end

    // Plain primary stage with wrap past 4096 (R2).
    do_reset(12'd1000, 15'd0, 15'd0, 15'd0, 15'd0, 2'd3);
    for (int k = 0; k < 12; k++) cyc(1'b1, 1'b0, "R2");

    // NTSC-like setting, long run (R5).
    do_reset(12'd135, 15'd27456, 15'd20800, 15'd0, 15'd0, 2'd3);
    for (int k = 0; k < 3000; k++) cyc(1'b1, 1'b0, "R5");

    // PAL-like setting with gaps in pix_vld (R5, R6).
    do_reset(12'd168, 15'd27648, 15'd4122, 15'd625, 15'd67, 2'd3);
    for (int k = 0; k < 3000; k++) cyc((k % 3) != 0, 1'b0, ((k % 3) != 0) ? "R5" : "R6");

    // Field clear periods; eof with pixel on the same cycle (R7, R8, R9).
    for (int m = 0; m < 3; m++) begin
      do_reset(12'd168, 15'd27648, 15'd4122, 15'd625, 15'd67, 2'(m));
      for (int f = 0; f < 2 * (2 << m); f++) begin
        for (int k = 0; k < 7; k++) cyc(1'b1, 1'b0, "R5");
        cyc(1'b1, 1'b1, (((f + 1) % (2 << m)) == 0) ? "R8" : "R9");
      end
      // Lone pulses without pixels must still follow the period (R7).
      for (int f = 0; f < (2 << m); f++) begin
        cyc(1'b1, 1'b0, "R5");
        cyc(1'b0, 1'b1, "R7");
      end
    end

    // Code 3 never clears (R7).
    do_reset(12'd135, 15'd27456, 15'd20800, 15'd0, 15'd0, 2'd3);
    for (int f = 0; f < 20; f++) begin
      cyc(1'b1, 1'b0, "R7");
      cyc(1'b0, 1'b1, "R7");
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule